// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block listens, without driving anything, to a four-wire SPI link on which a host issues 8-bit commands to a peripheral whose control registers are arranged in four banks. Each frame runs from the chip-select fall to the chip-select rise. The block samples the bus in mode 0 from a system clock at least four times faster than SCK. It collects the byte pairs of the frame, decodes the header, and at the end of the frame issues one result record. The record holds the opcode, register address, bank, data byte, byte count and a set of error flags.

The monitor keeps its own copy of the peripheral's two bank-select bits, which may be partly known. It updates the copy by watching register writes, bit-set and bit-clear commands aimed at the bank control register, and system resets. From this copy and a per-bank map of registers that need a dummy byte, it judges whether each register read has a legal length. A second per-bank map marks addresses that must not be accessed.

Top module: `spi_cmd_monitor`

## Requirements
- R1: A frame that carried at least one byte yields exactly one record. `rec_valid` is high for a single cycle, on the third clock edge after a chip-select rise reaches the pins. A frame with no bytes yields no record. After reset, `rec_valid` and `rec_err` are 0.
- R2: The header is the first byte of the frame. Bits [7:5] give `rec_opcode` and bits [4:0] give `rec_addr`. The opcode codes are: 000 read register, 001 read buffer, 010 write register, 011 write buffer, 100 bit set, 101 bit clear, 111 system reset.
- R3: Opcode 110 sets error bit 0 (unknown opcode).
- R4: A read-buffer frame needs the exact header 0x3A, and a write-buffer frame needs 0x7A. Any other header with those opcodes sets error bit 1. For these frames `rec_data` is byte 2 of the frame, taken from MISO for a read and from MOSI for a write.
- R5: Write register, bit set and bit clear must carry exactly 2 bytes, and system reset exactly 1. Any other count sets error bit 2. For the first three, `rec_data` is MOSI byte 2.
- R6: A register read needs 2 or 3 bytes. With the bank known, it needs 3 bytes where DUMMY_MASK bit {bank,addr} is 1 and 2 bytes otherwise. A wrong count sets error bit 2. `rec_data` is MISO byte 3 for a 3-byte read and MISO byte 2 otherwise.
- R7: A write register frame of legal length to address 0x1F loads the bank from bits [1:0] of its data byte and makes both bank bits known.
- R8: A bit-set frame of legal length to 0x1F sets each bank bit whose mask bit (data bits [1:0]) is 1. A bit-clear frame clears each such bit. In both cases each masked bit becomes known, and unmasked bits keep both their value and their known state.
- R9: A 1-byte system reset frame forces the bank to 0 and marks it known. A frame with an illegal length leaves the bank copy unchanged.
- R10: `rec_bank` and `rec_bank_known` show the bank copy as it stood before the frame. Bits that are not known read as 0. While either bank bit is unknown, a register command (000, 010, 100, 101) sets error bit 3, and a register read of 2 or 3 bytes passes the length check.
- R11: With the bank known, a register command whose address has its RSVD_MASK bit {bank,addr} set raises error bit 4.
- R12: `rec_count` is the number of bytes in the frame and saturates at 255.
- R13: Bits are taken on SCK rising edges while chip-select is low, most significant bit first. Chip-select high clears any partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Observed SPI clock |
| spi_csn | input | 1 | Observed chip select, active low |
| spi_mosi | input | 1 | Observed host-to-peripheral data |
| spi_miso | input | 1 | Observed peripheral-to-host data |
| rec_valid | output | 1 | One-cycle strobe for a frame record |
| rec_opcode | output | 3 | Header opcode |
| rec_addr | output | 5 | Header register address |
| rec_bank | output | 2 | Bank copy before the frame |
| rec_bank_known | output | 1 | Both bank bits known |
| rec_data | output | 8 | Selected data byte |
| rec_count | output | 8 | Saturated byte count |
| rec_err | output | 5 | Error flags: 0 opcode, 1 header, 2 length, 3 bank unknown, 4 invalid register |

## Verification
A record is due on the third clock edge after the chip-select rise is applied. Two edges go to synchronising the pin and one to registering the record. A byte is counted on the fourth edge after its eighth SCK rise. The driver therefore holds each SCK level for four clocks and waits four clocks before raising chip-select. When it raises chip-select, it notes the current cycle plus three as the due cycle of the predicted record. The monitor checks that each record arrives in exactly that cycle, and reports any record that appears with nothing expected.

// File: rtl/spimon_pkg.sv
package spimon_pkg;
  localparam int ADDR_W = 5;
  localparam int BANK_W = 2;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 8;
  localparam int ERR_W  = 5;
  localparam int MAP_W  = (1 << BANK_W) * (1 << ADDR_W);

  typedef enum logic [2:0] {
    OP_RD_REG   = 3'b000,
    OP_RD_BUF   = 3'b001,
    OP_WR_REG   = 3'b010,
    OP_WR_BUF   = 3'b011,
    OP_SET_BITS = 3'b100,
    OP_CLR_BITS = 3'b101,
    OP_UNDEF    = 3'b110,
    OP_RESET    = 3'b111
  } op_e;

  localparam int EB_OPCODE = 0;
  localparam int EB_HEADER = 1;
  localparam int EB_LENGTH = 2;
  localparam int EB_BANK   = 3;
  localparam int EB_REG    = 4;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] bank;
    logic              bank_known;
    logic [BYTE_W-1:0] data;
    logic [CNT_W-1:0]  count;
    logic [ERR_W-1:0]  err;
  } rec_t;
endpackage

// File: rtl/spimon_sync.sv
module spimon_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) st[0] <= rst ? RST_VAL : d;
    end else begin : g_next
      always_ff @(posedge clk) st[i] <= rst ? RST_VAL : st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spimon_shift.sv
module spimon_shift #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_rise,
  input  logic          cs_on,
  input  logic          mosi,
  input  logic          miso,
  output logic          byte_stb,
  output logic [BW-1:0] mosi_byte,
  output logic [BW-1:0] miso_byte
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic [CW-1:0] bitcnt;
  logic [BW-1:0] sh_o, sh_i;

  always_ff @(posedge clk) begin
    if (rst || !cs_on) begin
      bitcnt   <= '0;
      byte_stb <= 1'b0;
      if (rst) begin
        sh_o      <= '0;
        sh_i      <= '0;
        mosi_byte <= '0;
        miso_byte <= '0;
      end
    end else begin
      byte_stb <= 1'b0;
      if (sck_rise) begin
        sh_o <= {sh_o[BW-2:0], mosi};
        sh_i <= {sh_i[BW-2:0], miso};
        if (bitcnt == LAST) begin
          bitcnt    <= '0;
          byte_stb  <= 1'b1;
          mosi_byte <= {sh_o[BW-2:0], mosi};
          miso_byte <= {sh_i[BW-2:0], miso};
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  // R13: deselect discards any partial byte
  assert_partial_clear_R13: assert property (@(posedge clk) disable iff (rst)
    !cs_on |=> (bitcnt == '0) && !byte_stb);
endmodule

// File: rtl/spimon_frame.sv
module spimon_frame
  import spimon_pkg::*;
#(
  parameter logic [MAP_W-1:0] DUMMY_MASK = '0,
  parameter logic [MAP_W-1:0] RSVD_MASK  = '0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] mosi_byte,
  input  logic [BYTE_W-1:0] miso_byte,
  output logic              rec_valid,
  output rec_t              rec
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [BYTE_W-1:0] HDR_RBUF = 8'h3A;
  localparam logic [BYTE_W-1:0] HDR_WBUF = 8'h7A;

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] hdr, mo1, mi1, mi2;
  logic [BANK_W-1:0] bank_q, known_q;

  // ---- byte collection ----
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      hdr    <= '0;
      mo1    <= '0;
      mi1    <= '0;
      mi2    <= '0;
    end else if (cs_fall) begin
      active <= 1'b1;
      cnt    <= '0;
      hdr    <= '0;
      mo1    <= '0;
      mi1    <= '0;
      mi2    <= '0;
    end else begin
      if (cs_rise) active <= 1'b0;
      if (byte_stb && active) begin
        if (cnt == CNT_W'(0)) hdr <= mosi_byte;
        if (cnt == CNT_W'(1)) begin
          mo1 <= mosi_byte;
          mi1 <= miso_byte;
        end
        if (cnt == CNT_W'(2)) mi2 <= miso_byte;
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  // ---- classification ----
  op_e                      op;
  logic [ADDR_W-1:0]        addr;
  logic [BANK_W+ADDR_W-1:0] idx;
  logic                     bank_ok, need_dummy, rsvd, is_reg, to_ctrl;
  logic                     len_err;
  logic [ERR_W-1:0]         err;
  logic [BYTE_W-1:0]        data;
  logic                     commit;

  assign op         = op_e'(hdr[7:5]);
  assign addr       = hdr[ADDR_W-1:0];
  assign idx        = {bank_q, addr};
  assign bank_ok    = &known_q;
  assign need_dummy = DUMMY_MASK[idx];
  assign rsvd       = RSVD_MASK[idx];
  assign to_ctrl    = (addr == CTRL_ADDR);
  assign is_reg     = (op == OP_RD_REG) || (op == OP_WR_REG) ||
                      (op == OP_SET_BITS) || (op == OP_CLR_BITS);
  assign commit     = cs_rise && active && (cnt != '0);

  always_comb begin
    len_err = 1'b0;
    unique case (op)
      OP_RD_REG: begin
        if (cnt != CNT_W'(2) && cnt != CNT_W'(3)) len_err = 1'b1;
        else if (bank_ok) len_err = need_dummy ? (cnt != CNT_W'(3)) : (cnt != CNT_W'(2));
      end
      OP_WR_REG, OP_SET_BITS, OP_CLR_BITS: len_err = (cnt != CNT_W'(2));
      OP_RESET: len_err = (cnt != CNT_W'(1));
      default: len_err = 1'b0;
    endcase
  end

  always_comb begin
    err = '0;
    err[EB_OPCODE] = (op == OP_UNDEF);
    err[EB_HEADER] = ((op == OP_RD_BUF) && (hdr != HDR_RBUF)) ||
                     ((op == OP_WR_BUF) && (hdr != HDR_WBUF));
    err[EB_LENGTH] = len_err;
    err[EB_BANK]   = is_reg && !bank_ok;
    err[EB_REG]    = is_reg && bank_ok && rsvd;
  end

  always_comb begin
    unique case (op)
      OP_RD_REG: data = (cnt == CNT_W'(3)) ? mi2 : mi1;
      OP_RD_BUF: data = mi1;
      OP_WR_REG, OP_WR_BUF, OP_SET_BITS, OP_CLR_BITS: data = mo1;
      default: data = '0;
    endcase
  end

  // ---- bank shadow ----
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q  <= '0;
      known_q <= '0;
    end else if (commit && !len_err) begin
      unique case (op)
        OP_WR_REG: if (to_ctrl) begin
          bank_q  <= mo1[BANK_W-1:0];
          known_q <= '1;
        end
        OP_SET_BITS: if (to_ctrl) begin
          bank_q  <= bank_q | mo1[BANK_W-1:0];
          known_q <= known_q | mo1[BANK_W-1:0];
        end
        OP_CLR_BITS: if (to_ctrl) begin
          bank_q  <= bank_q & ~mo1[BANK_W-1:0];
          known_q <= known_q | mo1[BANK_W-1:0];
        end
        OP_RESET: begin
          bank_q  <= '0;
          known_q <= '1;
        end
        default: ;
      endcase
    end
  end

  // ---- record register ----
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec       <= '0;
    end else begin
      rec_valid <= commit;
      if (commit) begin
        rec.op         <= op;
        rec.addr       <= addr;
        rec.bank       <= bank_q & known_q;
        rec.bank_known <= bank_ok;
        rec.data       <= data;
        rec.count      <= cnt;
        rec.err        <= err;
      end
    end
  end

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid);

  assert_undef_flag_R3: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec.op == OP_UNDEF |-> rec.err[EB_OPCODE]);

  assert_read_len_R6: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec.op == OP_RD_REG && !rec.err[EB_LENGTH]
      |-> (rec.count == CNT_W'(2)) || (rec.count == CNT_W'(3)));

  assert_bank_load_R7: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec.op == OP_WR_REG && rec.addr == CTRL_ADDR && !rec.err[EB_LENGTH]
      |-> (bank_q == mo1[BANK_W-1:0]) && (&known_q));

  assert_reset_bank_R9: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec.op == OP_RESET && !rec.err[EB_LENGTH]
      |-> (bank_q == '0) && (&known_q));

  assert_bank_flag_R10: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec.err[EB_BANK] |-> !rec.bank_known);

  assert_count_sat_R12: assert property (@(posedge clk) disable iff (rst)
    byte_stb && active && !cs_fall && cnt == CNT_MAX |=> cnt == CNT_MAX);
endmodule

// File: rtl/spi_cmd_monitor.sv
module spi_cmd_monitor
  import spimon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [MAP_W-1:0] DUMMY_MASK = {32'h0000_003F, 32'h03FF_FFFF, 32'h0, 32'h0},
  parameter logic [MAP_W-1:0] RSVD_MASK  = {4{32'h0400_0000}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  input  logic              spi_miso,
  output logic              rec_valid,
  output logic [2:0]        rec_opcode,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [BANK_W-1:0] rec_bank,
  output logic              rec_bank_known,
  output logic [BYTE_W-1:0] rec_data,
  output logic [CNT_W-1:0]  rec_count,
  output logic [ERR_W-1:0]  rec_err
);
  logic [3:0] s;
  logic       s_csn, s_sck, s_mosi, s_miso;
  logic       csn_d, sck_d;
  logic       cs_fall, cs_rise, sck_rise;
  logic       byte_stb;
  logic [BYTE_W-1:0] mosi_byte, miso_byte;
  rec_t       rec;

  spimon_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_csn, spi_sck, spi_mosi, spi_miso}),
    .q(s)
  );
  assign {s_csn, s_sck, s_mosi, s_miso} = s;

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      csn_d <= s_csn;
      sck_d <= s_sck;
    end
  end

  assign cs_fall  = csn_d && !s_csn;
  assign cs_rise  = !csn_d && s_csn;
  assign sck_rise = !sck_d && s_sck && !s_csn;

  spimon_shift #(.BW(BYTE_W)) u_shift (
    .clk(clk), .rst(rst),
    .sck_rise(sck_rise), .cs_on(!s_csn),
    .mosi(s_mosi), .miso(s_miso),
    .byte_stb(byte_stb), .mosi_byte(mosi_byte), .miso_byte(miso_byte)
  );

  spimon_frame #(.DUMMY_MASK(DUMMY_MASK), .RSVD_MASK(RSVD_MASK)) u_frame (
    .clk(clk), .rst(rst),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .byte_stb(byte_stb), .mosi_byte(mosi_byte), .miso_byte(miso_byte),
    .rec_valid(rec_valid), .rec(rec)
  );

  assign rec_opcode     = rec.op;
  assign rec_addr       = rec.addr;
  assign rec_bank       = rec.bank;
  assign rec_bank_known = rec.bank_known;
  assign rec_data       = rec.data;
  assign rec_count      = rec.count;
  assign rec_err        = rec.err;

  // R13: a byte strobe only occurs while selected
  assert_stb_in_frame_R13: assert property (@(posedge clk) disable iff (rst)
    byte_stb |-> $past(!s_csn));
endmodule

// File: tb/spi_cmd_monitor_test.sv
module spi_cmd_monitor_test;
  import spimon_pkg::*;

  localparam logic [MAP_W-1:0] DMASK = {32'h0000_003F, 32'h03FF_FFFF, 32'h0, 32'h0};
  localparam logic [MAP_W-1:0] RMASK = {4{32'h0400_0000}};

  logic clk = 0, rst = 1;
  logic spi_sck = 0, spi_csn = 1, spi_mosi = 0, spi_miso = 0;
  logic rec_valid, rec_bank_known;
  logic [2:0] rec_opcode;
  logic [4:0] rec_addr;
  logic [1:0] rec_bank;
  logic [7:0] rec_data, rec_count;
  logic [4:0] rec_err;

  always #2 clk = ~clk;

  spi_cmd_monitor #(.DUMMY_MASK(DMASK), .RSVD_MASK(RMASK)) uut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rec_valid(rec_valid),
    .rec_opcode(rec_opcode), .rec_addr(rec_addr), .rec_bank(rec_bank),
    .rec_bank_known(rec_bank_known), .rec_data(rec_data),
    .rec_count(rec_count), .rec_err(rec_err)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [33:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];
  logic [7:0]  tx_m[$], tx_s[$];
  logic [1:0]  mb, mk;

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rec_valid) begin
      logic [33:0] got;
      got = {rec_opcode, rec_addr, rec_bank, rec_bank_known, rec_data, rec_count, rec_err};
      if (exp_q.size() == 0) begin
        check(0, "R1 unexpected record", 64'(got), 64'(0));
      end else begin
        logic [33:0] e; int d; string t;
        e = exp_q.pop_front(); d = due_q.pop_front(); t = tag_q.pop_front();
        check(got === e, t, 64'(got), 64'(e));
        check(cyc == d, {t, " R1 latency"}, 64'(cyc), 64'(d));
      end
    end
  end

  task automatic add(input logic [7:0] m, input logic [7:0] s);
    tx_m.push_back(m); tx_s.push_back(s);
  endtask

  // Reference model written from the requirements
  task automatic predict(output logic [33:0] r);
    int n; logic [7:0] hdr, m1, s1, s2, cnt, data; logic [2:0] op; logic [4:0] a;
    logic known, need, rsv, isreg, lerr; logic [4:0] err; int idx;
    n = tx_m.size();
    hdr = tx_m[0]; op = hdr[7:5]; a = hdr[4:0];
    cnt = (n > 255) ? 8'd255 : 8'(n);
    m1 = (n > 1) ? tx_m[1] : 8'h0; s1 = (n > 1) ? tx_s[1] : 8'h0; s2 = (n > 2) ? tx_s[2] : 8'h0;
    known = &mk; idx = int'(mb) * 32 + int'(a);
    need = DMASK[idx]; rsv = RMASK[idx];
    isreg = (op == 3'b000) || (op == 3'b010) || (op == 3'b100) || (op == 3'b101);
    lerr = 0;
    case (op)
      3'b000: lerr = (n != 2 && n != 3) ? 1'b1 : (known ? (need ? n != 3 : n != 2) : 1'b0);
      3'b010, 3'b100, 3'b101: lerr = (n != 2);
      3'b111: lerr = (n != 1);
      default: lerr = 0;
    endcase
    err = {isreg && known && rsv, isreg && !known, lerr,
           (op == 3'b001 && hdr != 8'h3A) || (op == 3'b011 && hdr != 8'h7A), op == 3'b110};
    case (op)
      3'b000: data = (n == 3) ? s2 : s1;
      3'b001: data = s1;
      3'b010, 3'b011, 3'b100, 3'b101: data = m1;
      default: data = 0;
    endcase
    r = {op, a, mb & mk, known, data, cnt, err};
    if (!lerr) begin
      if (op == 3'b010 && a == 5'h1F) begin mb = m1[1:0]; mk = 2'b11; end
      if (op == 3'b100 && a == 5'h1F) begin mb = mb | m1[1:0]; mk = mk | m1[1:0]; end
      if (op == 3'b101 && a == 5'h1F) begin mb = mb & ~m1[1:0]; mk = mk | m1[1:0]; end
      if (op == 3'b111) begin mb = 0; mk = 2'b11; end
    end
  endtask

  task automatic run_frame(input string tag);
    logic [33:0] r;
    @(negedge clk); spi_csn = 0;
    repeat (4) @(negedge clk);
    foreach (tx_m[i]) begin
      for (int b = 7; b >= 0; b--) begin
        spi_mosi = tx_m[i][b]; spi_miso = tx_s[i][b];
        repeat (4) @(negedge clk); spi_sck = 1;
        repeat (4) @(negedge clk); spi_sck = 0;
      end
    end
    repeat (4) @(negedge clk);
    if (tx_m.size() > 0) begin
      predict(r);
      exp_q.push_back(r); due_q.push_back(cyc + 3); tag_q.push_back(tag);
    end
    spi_csn = 1;
    repeat (8) @(negedge clk);
    tx_m.delete(); tx_s.delete();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; mb = 0; mk = 0;
    repeat (3) @(negedge clk); rst = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 64'(cyc), 64'(0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mb = 0; mk = 0;
    do_reset();
    check(rec_valid == 0 && rec_err == 0, "R1 reset state", 64'({rec_valid, rec_err}), 64'(0));

    run_frame("R1 empty frame");                            // no record expected
    add(8'h05, 8'h00); add(8'h00, 8'hA5); run_frame("R10 read with bank unknown");
    add(8'h05, 8'h00); add(8'h00, 8'h00); add(8'h00, 8'h3C); run_frame("R10 3-byte read unknown bank");
    add(8'hFF, 8'h00); run_frame("R9 system reset");
    add(8'h05, 8'h00); add(8'h00, 8'h5A); run_frame("R6 R2 plain read bank0");
    add(8'h05, 8'h00); add(8'h00, 8'h11); add(8'h00, 8'h22); run_frame("R6 extra dummy byte");
    add(8'h5F, 8'h00); add(8'h02, 8'h00); run_frame("R7 write bank 2");
    add(8'h03, 8'h00); add(8'h00, 8'h11); add(8'h00, 8'hC3); run_frame("R6 dummy read bank2");
    add(8'h03, 8'h00); add(8'h00, 8'h77); run_frame("R6 missing dummy");
    add(8'h9F, 8'h00); add(8'h01, 8'h00); run_frame("R8 bit set to bank 3");
    add(8'hBF, 8'h00); add(8'h02, 8'h00); run_frame("R8 bit clear to bank 1");
    add(8'h1A, 8'h00); add(8'h00, 8'h44); run_frame("R11 reserved address");
    add(8'hC4, 8'h00); add(8'h00, 8'h00); run_frame("R3 undefined opcode");
    add(8'h3A, 8'h00); add(8'h00, 8'hDE); add(8'h00, 8'hAD); add(8'h00, 8'hBE); run_frame("R4 read buffer");
    add(8'h3B, 8'h00); add(8'h00, 8'h12); run_frame("R4 bad read header");
    add(8'h7A, 8'h00); add(8'h96, 8'h00); add(8'h69, 8'h00); run_frame("R4 write buffer");
    add(8'h5F, 8'h00); add(8'h03, 8'h00); add(8'h00, 8'h00); run_frame("R5 long write ignored");
    add(8'h05, 8'h00); add(8'h00, 8'h81); run_frame("R9 bank kept after bad write");
    add(8'hFF, 8'h00); add(8'h00, 8'h00); run_frame("R5 long reset");
    add(8'h8F, 8'h00); run_frame("R5 short bit set");
    do_reset();
    add(8'h9F, 8'h00); add(8'h01, 8'h00); run_frame("R8 partial set unknown");
    add(8'h05, 8'h00); add(8'h00, 8'h33); run_frame("R8 R10 still unknown");
    add(8'h9F, 8'h00); add(8'h02, 8'h00); run_frame("R8 second bit known");
    add(8'h05, 8'h00); add(8'h00, 8'h66); run_frame("R8 bank 3 read");
    // R13: partial byte then deselect, next frame must start clean
    @(negedge clk); spi_csn = 0; repeat (4) @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      spi_mosi = 1; repeat (4) @(negedge clk); spi_sck = 1; repeat (4) @(negedge clk); spi_sck = 0;
    end
    repeat (4) @(negedge clk); spi_csn = 1; repeat (8) @(negedge clk);
    add(8'hFF, 8'h00); run_frame("R13 clean after partial byte");
    add(8'h7A, 8'h00);
    for (int i = 0; i < 260; i++) add(8'(i), 8'h00);
    run_frame("R12 saturated count");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R1 missing record", 64'(exp_q.size()), 64'(0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule